// File: doc/BRIEF.md
# Multi-Channel Timer/Counter Bank

This block is a register-mapped peripheral that holds a parameterised number of independent 32-bit timer channels. Software programs each channel through three registers: a control/status word, a reload value and a live counter. A channel counts up or down from its reload value on every cycle where the shared tick input is high. When it expires it raises its expiry flag and either reloads and continues or stops.

Each channel turns its expiry flag and its interrupt-enable bit into an interrupt request. The requests are ORed into one level-sensitive interrupt output. The output stays high until software writes the control word of every flagged channel, which clears that channel's flag. Software reads the counter at any time, and the value it reads is always the live count in the selected direction. The control bits for mode, generate, capture, load, PWM and enable-all are stored and read back but have no effect.

Top module: `tmr_bank`

## Requirements
- R1: After reset every control, reload and counter register reads 0, every channel is stopped and irq_o is low.
- R2: addr_i is a word address. Bits [1:0] select the register: 0 control, 1 reload, 2 counter. The bits above select the channel. Control bits: 1 count-down, 4 auto-reload, 6 interrupt enable, 7 run, 8 expiry flag. Bits 0, 2, 3, 5, 9 and 10 are stored and read back but have no effect.
- R3: A control write stores wdata_i with bit 8 forced to 0, so it always clears a pending expiry flag.
- R4: A control write with bit 7 set loads the counter from the reload register and starts the channel. A control write with bit 7 clear stops it, and the counter keeps its value.
- R5: With bit 1 set, each tick decrements the counter. A tick that finds the counter at 1 or 0 is an expiry.
- R6: With bit 1 clear, each tick increments the counter. A tick that finds the counter at all-ones is an expiry.
- R7: The counter changes only on a cycle where tick_i is high and the channel is running, or on a control write with bit 7 set.
- R8: An expiry sets bit 8. If bit 4 is set, the counter reloads from the reload register and the channel keeps running. Otherwise the counter becomes 0 and the channel stops.
- R9: irq_o is high exactly when some channel has both bit 8 and bit 6 set.
- R10: A reload-register write does not change a running count. The new value is used at the next enabling control write or auto-reload.
- R11: Reads of register 3 and of channels at or above NUM_CH return 0, and writes to them are ignored. Writes to the counter register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable, one step per high cycle |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| irq_o | output | 1 | Shared level interrupt |

## Verification
The bench targets the edges of the expiry rule. In up mode it starts a count just below all-ones with auto-reload set. A design with an off-by-one expiry would reload one tick early or late, or would wrap to zero when it should reload. A reload write in the middle of that count checks that the count is not disturbed; a design that copies the load value straight into the counter would return the new value. It also checks that a flag with its interrupt enable clear keeps irq_o low, that a one-shot channel stops at zero, and that a control write with bit 8 set still clears the flag. Writes to the counter register, to word 3 and to an unmapped channel must not corrupt live state.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CSR_DOWN = 1;
  localparam int unsigned CSR_AUTO = 4;
  localparam int unsigned CSR_IE   = 6;
  localparam int unsigned CSR_RUN  = 7;
  localparam int unsigned CSR_FLAG = 8;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_LOAD = 2'd1,
    REG_CNT  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         ctrl_we_i,
  input  logic         load_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ctrl_o,
  output logic [W-1:0] load_o,
  output logic [W-1:0] cnt_o,
  output logic         irq_o
);
  localparam logic [W-1:0] FLAG_CLR = ~(W'(1) << CSR_FLAG);

  logic [W-1:0] ctrl_q, load_q, cnt_q;
  logic         run_q;
  logic         step, down, expire;

  assign down   = ctrl_q[CSR_DOWN];
  assign step   = run_q & tick_i;
  assign expire = step & (down ? (cnt_q <= W'(1)) : (cnt_q == '1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      load_q <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
    end else begin
      if (load_we_i) load_q <= wdata_i;
      if (ctrl_we_i) begin
        ctrl_q <= wdata_i & FLAG_CLR;
        run_q  <= wdata_i[CSR_RUN];
        if (wdata_i[CSR_RUN]) cnt_q <= load_q;
      end else if (step) begin
        if (expire) begin
          ctrl_q[CSR_FLAG] <= 1'b1;
          if (ctrl_q[CSR_AUTO]) begin
            cnt_q <= load_q;
          end else begin
            cnt_q <= '0;
            run_q <= 1'b0;
          end
        end else begin
          cnt_q <= down ? cnt_q - W'(1) : cnt_q + W'(1);
        end
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign load_o = load_q;
  assign cnt_o  = cnt_q;
  assign irq_o  = ctrl_q[CSR_FLAG] & ctrl_q[CSR_IE];

  p_flag_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> !ctrl_q[CSR_FLAG]);
  p_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && wdata_i[CSR_RUN] |=> run_q && cnt_q == $past(load_q));
  p_down_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && down && !ctrl_we_i && cnt_q > W'(1) |=> cnt_q == $past(cnt_q) - W'(1));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i && !(run_q && tick_i) |=> $stable(cnt_q));
  p_oneshot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire && !ctrl_we_i && !ctrl_q[CSR_AUTO] |=> !run_q && ctrl_q[CSR_FLAG] && cnt_q == '0);
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [NUM_CH-1:0][W-1:0]   ctrl_i,
  input  logic [NUM_CH-1:0][W-1:0]   load_i,
  input  logic [NUM_CH-1:0][W-1:0]   cnt_i,
  output logic [W-1:0]               rdata_o
);
  localparam int unsigned CW = ADDR_W - 2;

  logic [CW-1:0] ch;
  reg_sel_e      sel;

  assign ch  = addr_i[ADDR_W-1:2];
  assign sel = reg_sel_e'(addr_i[1:0]);

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < int'(NUM_CH); i++) begin
      if (ch == CW'(i)) begin
        unique case (sel)
          REG_CTRL: rdata_o = ctrl_i[i];
          REG_LOAD: rdata_o = load_i[i];
          REG_CNT:  rdata_o = cnt_i[i];
          default:  rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int unsigned W  = 32;
  localparam int unsigned CW = ADDR_W - 2;

  logic [NUM_CH-1:0][W-1:0] ctrl, load, cnt;
  logic [NUM_CH-1:0]        irq_ch;
  logic [CW-1:0]            ch;
  reg_sel_e                 sel;

  assign ch  = addr_i[ADDR_W-1:2];
  assign sel = reg_sel_e'(addr_i[1:0]);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = we_i && (ch == CW'(g));
    tmr_chan #(.W(W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .ctrl_we_i (hit && sel == REG_CTRL),
      .load_we_i (hit && sel == REG_LOAD),
      .wdata_i   (wdata_i),
      .ctrl_o    (ctrl[g]),
      .load_o    (load[g]),
      .cnt_o     (cnt[g]),
      .irq_o     (irq_ch[g])
    );
  end

  tmr_rdmux #(.NUM_CH(NUM_CH), .W(W), .ADDR_W(ADDR_W)) u_rdmux (
    .addr_i  (addr_i),
    .ctrl_i  (ctrl),
    .load_i  (load),
    .cnt_i   (cnt),
    .rdata_o (rdata_o)
  );

  assign irq_o = |irq_ch;

  p_unmapped_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel == REG_NONE |-> rdata_o == '0);
endmodule

// File: tb/tmr_bank_bench.sv
module tmr_bank_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        rd_stb = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  tmr_bank u_tmr_bank (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // monitor: scoreboard of expected read data
  always @(negedge clk) begin
    if (rd_stb && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rdata !== e) begin
        bad++;
        $display("FAIL %s: addr=%0d got=%h exp=%h", t, addr, rdata, e);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    addr = a; rd_stb = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    rd_stb = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; tick = 1'b1;
    end
    @(posedge clk); #1; tick = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s: irq got=%b exp=%b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got=timeout exp=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R1 reset state
    rd(0, 32'h0, "R1 ctrl0");
    rd(2, 32'h0, "R1 cnt0");
    rd(5, 32'h0, "R1 load1");
    chk_irq(1'b0, "R1 irq");

    // R5 down count, one-shot, irq enabled
    wr(1, 32'd5);
    wr(0, 32'h0000_00C2);
    rd(2, 32'd5, "R4 start load");
    ticks(3);
    rd(2, 32'd2, "R5 decrement");
    ticks(1);
    rd(2, 32'd1, "R5 at one");
    ticks(1);
    rd(2, 32'd0, "R5 expire count");
    rd(0, 32'h0000_01C2, "R8 flag set");
    chk_irq(1'b1, "R9 irq raised");
    ticks(2);
    rd(2, 32'd0, "R8 one-shot stopped");
    wr(0, 32'h0000_0042);
    chk_irq(1'b0, "R3 flag cleared irq low");
    rd(0, 32'h0000_0042, "R3 ctrl after clear");

    // R6 up count with auto-reload, R10 load write mid-run
    wr(5, 32'hFFFF_FFFD);
    wr(4, 32'h0000_00D0);
    rd(6, 32'hFFFF_FFFD, "R4 up start");
    ticks(1);
    rd(6, 32'hFFFF_FFFE, "R6 increment");
    wr(5, 32'h0000_0010);
    rd(6, 32'hFFFF_FFFE, "R10 load write no effect");
    ticks(1);
    rd(6, 32'hFFFF_FFFF, "R6 at all-ones");
    ticks(1);
    rd(6, 32'h0000_0010, "R8 auto-reload value");
    rd(4, 32'h0000_01D0, "R8 flag up");
    chk_irq(1'b1, "R9 irq from ch1");
    ticks(1);
    rd(6, 32'h0000_0011, "R8 keeps running");
    wr(4, 32'h0);
    chk_irq(1'b0, "R9 irq cleared");
    ticks(3);
    rd(6, 32'h0000_0011, "R4 stop holds count");

    // R7 tick low, R9 masked flag
    wr(1, 32'd7);
    wr(0, 32'h0000_0082);
    repeat (5) @(posedge clk);
    rd(2, 32'd7, "R7 no tick hold");
    ticks(1);
    rd(2, 32'd6, "R7 single tick");
    ticks(6);
    rd(0, 32'h0000_0182, "R8 masked flag set");
    chk_irq(1'b0, "R9 masked irq low");
    wr(0, 32'h0000_0142);
    rd(0, 32'h0000_0042, "R3 written flag bit dropped");
    chk_irq(1'b0, "R3 irq low after write");

    // R11 unmapped and counter writes
    wr(9, 32'h55);
    rd(9, 32'h0, "R11 out-of-range read");
    rd(8, 32'h0, "R11 out-of-range ctrl");
    wr(3, 32'h77);
    rd(3, 32'h0, "R11 word3 read");
    wr(6, 32'h99);
    rd(6, 32'h0000_0011, "R11 counter write ignored");
    rd(1, 32'd7, "R11 ch0 load intact");

    // R2 inert control bits
    wr(4, 32'h0000_060D);
    rd(4, 32'h0000_060D, "R2 inert bits stored");
    ticks(2);
    rd(6, 32'h0000_0011, "R2 inert bits no count");

    // R6 one-shot up wrap
    wr(1, 32'hFFFF_FFFF);
    wr(0, 32'h0000_00C0);
    ticks(1);
    rd(2, 32'h0, "R6 wrap expire zero");
    chk_irq(1'b1, "R9 irq up one-shot");
    ticks(2);
    rd(2, 32'h0, "R8 up one-shot stopped");

    @(negedge clk); @(negedge clk);
    finish_run();
  end
endmodule